// File: doc/BRIEF.md
# Vector Lane Predicate Mask Unit

This block produces the per-byte-lane enable mask for a 128-bit vector execution unit and keeps the predication state that governs it. The mask starts from a stored 16-bit predicate field. Two 4-bit block masks, one for each half of the vector, say whether the predicate applies to that half. The mask is then cut back on the final iteration of a tail-predicated loop. Lanes of beats already completed before an interrupted instruction resumes are also removed. A bit value of 1 lets a lane write. Byte operations use all 16 bits. Halfword operations read every second bit, and word operations read bits 0, 4, 8 and 12.

The predicate field, both block masks and the 8-bit condition/beat state are held in registers inside the block. They are written through a load port. After each vector instruction, an advance strobe steps them: the block masks shift toward expiry, predicate halves flip where the block mask asks for it, and the resumed-beat code retires. The loop count and the tail element-size code arrive as live inputs. The mask is combinational from the registered state and those inputs.

Top module: `lane_pred_unit`

## Requirements
- R1: After reset the predicate field, both block masks and the beat state are zero, `lane_mask` reads 16'hFFFF and `beat_err` is 0.
- R2: The base mask is the predicate field. Bits 7:0 are forced to 1 when the low block mask is zero, and bits 15:8 are forced to 1 when the high block mask is zero.
- R3: When `tail_size` is below 4 and `loop_count` is at most 1 << (4 − `tail_size`), only the lowest (`loop_count` << `tail_size`) mask bits survive and the rest are cleared. Otherwise there is no truncation, including every size code of 4 or more.
- R4: Beat masking applies only when bits 3:0 of the beat state are zero, with the code in bits 7:4. Code 1 clears mask bits 3:0, code 2 clears bits 7:0, and codes 3 and 4 clear bits 11:0. Code 0 clears nothing.
- R5: A code from 5 to 15 with bits 3:0 zero clears nothing and drives `beat_err` to 1. In all other cases `beat_err` is 0.
- R6: On advance with bits 3:0 of the beat state zero, state 8'h40 becomes 8'h10 and any other state becomes 8'h00. With bits 3:0 nonzero, the beat state is unchanged.
- R7: On advance with both block masks zero, the predicate field and the block masks are unchanged.
- R8: On advance with either block mask nonzero, a block mask above 4'b1000 inverts its half of the predicate field (low mask: bits 7:0, high mask: bits 15:8). A mask of exactly 4'b1000 or below does not invert. Each block mask then shifts left by one bit within its 4 bits.
- R9: A load writes all state at the next clock edge and takes priority over a simultaneous advance.
- R10: When several causes are active, the final mask is the AND of the base, tail and beat masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write all state from the load inputs |
| load_p0 | input | 16 | Predicate field to load |
| load_blk_lo | input | 4 | Low-half block mask to load |
| load_blk_hi | input | 4 | High-half block mask to load |
| load_beat | input | 8 | Condition/beat state to load |
| adv | input | 1 | Step state after an instruction |
| loop_count | input | 32 | Remaining loop element count |
| tail_size | input | 3 | Tail element-size code (log2 bytes) |
| lane_mask | output | 16 | Active byte-lane mask |
| beat_err | output | 1 | Unknown beat code present |
| p0_q | output | 16 | Current predicate field |
| blk_lo_q | output | 4 | Current low block mask |
| blk_hi_q | output | 4 | Current high block mask |
| beat_q | output | 8 | Current condition/beat state |

## Verification
`lane_mask` and `beat_err` are combinational. They reflect `loop_count`, `tail_size` and the registered state in the same cycle, with no register in between. The state outputs change at the first rising edge where `load_en` or `adv` is seen high. The bench drives every input on a falling edge. Mask checks are sampled at the next falling edge with no clock edge needed. Load and advance checks are sampled one falling edge after the rising edge that commits them. Each check therefore lands half a period away from any edge and counts exactly the one register on the path.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [3:0] {
    BT_NONE    = 4'd0,
    BT_B0      = 4'd1,
    BT_B01     = 4'd2,
    BT_B012    = 4'd3,
    BT_B012_N0 = 4'd4
  } beat_code_e;

  // number of completed beats whose lanes must be masked off
  function automatic logic [1:0] beats_done(input logic [3:0] code);
    case (code)
      BT_B0:                 beats_done = 2'd1;
      BT_B01:                beats_done = 2'd2;
      BT_B012, BT_B012_N0:   beats_done = 2'd3;
      default:               beats_done = 2'd0;
    endcase
  endfunction

  function automatic logic beat_code_known(input logic [3:0] code);
    beat_code_known = (code <= BT_B012_N0);
  endfunction

  // next beat state on advance, for an 8-bit state with code in [7:4]
  function automatic logic [7:0] beat_step(input logic [7:0] st);
    if (st[3:0] != 4'd0) beat_step = st;
    else if (st[7:4] == BT_B012_N0) beat_step = {BT_B0, 4'd0};
    else beat_step = 8'd0;
  endfunction

  // tail-length: number of surviving lanes, valid only when tail applies
  function automatic logic [4:0] tail_lanes(input logic [4:0] cnt, input logic [1:0] sz);
    tail_lanes = cnt << sz;
  endfunction

endpackage

// File: rtl/lpm_tail.sv
module lpm_tail #(
  parameter int LANES = 16,
  parameter int CNT_W = 32,
  parameter int SZ_W  = 3
) (
  input  logic [CNT_W-1:0] loop_count,
  input  logic [SZ_W-1:0]  tail_size,
  output logic             tail_on,
  output logic [4:0]       tail_len,
  output logic [LANES-1:0] tail_keep
);
  import lpm_pkg::*;

  logic       size_ok;
  logic [4:0] limit;

  always_comb begin
    size_ok  = (tail_size < SZ_W'(4));
    limit    = size_ok ? (5'd1 << (3'd4 - 3'(tail_size[1:0]))) : 5'd0;
    tail_on  = size_ok && (loop_count <= CNT_W'(limit));
    tail_len = tail_lanes(loop_count[4:0], tail_size[1:0]);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign tail_keep[i] = !tail_on || (5'(i) < tail_len);
  end

endmodule

// File: rtl/lpm_beat.sv
module lpm_beat #(
  parameter int LANES  = 16,
  parameter int BEAT_W = 8
) (
  input  logic [BEAT_W-1:0] beat_state,
  output logic              beat_on,
  output logic              beat_err,
  output logic [LANES-1:0]  beat_keep,
  output logic [BEAT_W-1:0] beat_nxt
);
  import lpm_pkg::*;

  localparam int QW = LANES / 4;

  logic [3:0] code;
  logic [1:0] done;

  always_comb begin
    code     = beat_state[7:4];
    beat_on  = (beat_state[3:0] == 4'd0);
    beat_err = beat_on && !beat_code_known(code);
    done     = beat_on ? beats_done(code) : 2'd0;
    beat_nxt = beat_step(beat_state);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign beat_keep[i] = ((i / QW) >= int'(done));
  end

endmodule

// File: rtl/lpm_blk_step.sv
module lpm_blk_step #(
  parameter int HALF  = 8,
  parameter int BLK_W = 4
) (
  input  logic [BLK_W-1:0] blk,
  input  logic [HALF-1:0]  p0_half,
  output logic [HALF-1:0]  half_mask,
  output logic             flip,
  output logic [BLK_W-1:0] blk_nxt,
  output logic [HALF-1:0]  p0_nxt
);
  always_comb begin
    half_mask = (blk == '0) ? '1 : p0_half;
    flip      = blk[BLK_W-1] && (blk[BLK_W-2:0] != '0);
    blk_nxt   = {blk[BLK_W-2:0], 1'b0};
    p0_nxt    = flip ? ~p0_half : p0_half;
  end
endmodule

// File: rtl/lane_pred_unit.sv
module lane_pred_unit #(
  parameter int LANES  = 16,
  parameter int BLK_W  = 4,
  parameter int BEAT_W = 8,
  parameter int CNT_W  = 32,
  parameter int SZ_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [LANES-1:0]  load_p0,
  input  logic [BLK_W-1:0]  load_blk_lo,
  input  logic [BLK_W-1:0]  load_blk_hi,
  input  logic [BEAT_W-1:0] load_beat,
  input  logic              adv,
  input  logic [CNT_W-1:0]  loop_count,
  input  logic [SZ_W-1:0]   tail_size,
  output logic [LANES-1:0]  lane_mask,
  output logic              beat_err,
  output logic [LANES-1:0]  p0_q,
  output logic [BLK_W-1:0]  blk_lo_q,
  output logic [BLK_W-1:0]  blk_hi_q,
  output logic [BEAT_W-1:0] beat_q
);
  localparam int NHALF = 2;
  localparam int HALF  = LANES / NHALF;

  logic [NHALF-1:0][BLK_W-1:0] blk_q;
  logic [NHALF-1:0][BLK_W-1:0] blk_nxt;
  logic [LANES-1:0]            p0_nxt;
  logic [LANES-1:0]            base_mask;
  logic [NHALF-1:0]            flip;
  logic                        vpt_on;

  logic                        tail_on;
  logic [4:0]                  tail_len;
  logic [LANES-1:0]            tail_keep;
  logic                        beat_on;
  logic [LANES-1:0]            beat_keep;
  logic [BEAT_W-1:0]           beat_nxt;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    lpm_blk_step #(.HALF(HALF), .BLK_W(BLK_W)) u_step (
      .blk       (blk_q[h]),
      .p0_half   (p0_q[h*HALF +: HALF]),
      .half_mask (base_mask[h*HALF +: HALF]),
      .flip      (flip[h]),
      .blk_nxt   (blk_nxt[h]),
      .p0_nxt    (p0_nxt[h*HALF +: HALF])
    );
  end

  lpm_tail #(.LANES(LANES), .CNT_W(CNT_W), .SZ_W(SZ_W)) u_tail (
    .loop_count (loop_count),
    .tail_size  (tail_size),
    .tail_on    (tail_on),
    .tail_len   (tail_len),
    .tail_keep  (tail_keep)
  );

  lpm_beat #(.LANES(LANES), .BEAT_W(BEAT_W)) u_beat (
    .beat_state (beat_q),
    .beat_on    (beat_on),
    .beat_err   (beat_err),
    .beat_keep  (beat_keep),
    .beat_nxt   (beat_nxt)
  );

  assign vpt_on    = (blk_q != '0);
  assign lane_mask = base_mask & tail_keep & beat_keep;
  assign blk_lo_q  = blk_q[0];
  assign blk_hi_q  = blk_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p0_q   <= '0;
      blk_q  <= '0;
      beat_q <= '0;
    end else if (load_en) begin
      p0_q     <= load_p0;
      blk_q[0] <= load_blk_lo;
      blk_q[1] <= load_blk_hi;
      beat_q   <= load_beat;
    end else if (adv) begin
      beat_q <= beat_nxt;
      if (vpt_on) begin
        p0_q  <= p0_nxt;
        blk_q <= blk_nxt;
      end
    end
  end

  // R3: lanes at or above the tail length are never active
  a_r3_tail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tail_on |-> ((lane_mask >> tail_len) == '0));

  // R4: code 2 with valid beat state leaves the low two beats idle
  a_r4_beat_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_on && beat_q[7:4] == 4'd2) |-> (lane_mask[7:0] == 8'h00));

  // R5: error flag only for an unknown code in valid beat state
  a_r5_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    beat_err |-> (beat_q[3:0] == 4'd0 && beat_q[7:4] > 4'd4));

  // R6: resumed second-instruction beat retires to the first-beat code
  a_r6_beat_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load_en && beat_q == 8'h40) |=> (beat_q == 8'h10));

  // R7: idle block masks keep the predicate field
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load_en && !vpt_on) |=> (p0_q == $past(p0_q)));

  // R8: the high half flips only when its block mask exceeds 4'b1000
  a_r8_hi_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load_en && blk_hi_q > 4'd8) |=> (p0_q[15:8] == ~$past(p0_q[15:8])));

  // R9: load wins over advance
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (p0_q == $past(load_p0) && beat_q == $past(load_beat)));

endmodule

// File: tb/lane_pred_unit_bench.sv
module lane_pred_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] load_p0 = '0;
  logic [3:0]  load_blk_lo = '0;
  logic [3:0]  load_blk_hi = '0;
  logic [7:0]  load_beat = '0;
  logic        adv = 1'b0;
  logic [31:0] loop_count = 32'd100;
  logic [2:0]  tail_size = 3'd4;
  logic [15:0] lane_mask;
  logic        beat_err;
  logic [15:0] p0_q;
  logic [3:0]  blk_lo_q, blk_hi_q;
  logic [7:0]  beat_q;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lane_pred_unit u_lane_pred_unit (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_p0(load_p0),
    .load_blk_lo(load_blk_lo), .load_blk_hi(load_blk_hi), .load_beat(load_beat),
    .adv(adv), .loop_count(loop_count), .tail_size(tail_size),
    .lane_mask(lane_mask), .beat_err(beat_err), .p0_q(p0_q),
    .blk_lo_q(blk_lo_q), .blk_hi_q(blk_hi_q), .beat_q(beat_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent per-lane model of the mask
  function automatic logic [15:0] model_mask(input logic [15:0] p, input logic [3:0] lo,
      input logic [3:0] hi, input logic [7:0] bt, input int cnt, input int sz);
    logic [15:0] m;
    int first_live;
    for (int b = 0; b < 16; b++) begin
      m[b] = p[b] | ((b < 8) ? (lo == 0) : (hi == 0));
      if (sz < 4 && cnt <= (16 >> sz) && b >= cnt * (1 << sz)) m[b] = 1'b0;
    end
    first_live = 0;
    if (bt[3:0] == 0) begin
      if (bt[7:4] == 1) first_live = 4;
      else if (bt[7:4] == 2) first_live = 8;
      else if (bt[7:4] == 3 || bt[7:4] == 4) first_live = 12;
    end
    for (int b = 0; b < first_live; b++) m[b] = 1'b0;
    return m;
  endfunction

  task automatic load(input logic [15:0] p, input logic [3:0] lo, input logic [3:0] hi,
      input logic [7:0] bt);
    @(negedge clk);
    load_en = 1'b1; load_p0 = p; load_blk_lo = lo; load_blk_hi = hi; load_beat = bt;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    adv = 1'b1;
    @(negedge clk);
    adv = 1'b0;
  endtask

  task automatic tail(input int cnt, input int sz);
    @(negedge clk);
    loop_count = cnt; tail_size = 3'(sz);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 mask", lane_mask, 16'hFFFF);
    chk("R1 p0", p0_q, 16'h0);
    chk("R1 blk", {blk_hi_q, blk_lo_q}, 8'h00);
    chk("R1 beat", beat_q, 8'h00);
    chk("R1 err", beat_err, 1'b0);
  endtask

  task automatic t_base();
    load(16'h1234, 4'h4, 4'h0, 8'h00);
    chk("R2 low block", lane_mask, 16'hFF34);
    load(16'h1234, 4'h0, 4'h2, 8'h00);
    chk("R2 high block", lane_mask, 16'h12FF);
    load(16'hA5C3, 4'h8, 4'h8, 8'h00);
    chk("R2 both blocks", lane_mask, 16'hA5C3);
  endtask

  task automatic t_tail();
    int cases[8][2] = '{'{5,0}, '{3,1}, '{2,2}, '{5,2}, '{1,4}, '{1,3}, '{0,0}, '{16,0}};
    load(16'h0000, 4'h0, 4'h0, 8'h00);
    foreach (cases[k]) begin
      tail(cases[k][0], cases[k][1]);
      chk($sformatf("R3 cnt=%0d sz=%0d", cases[k][0], cases[k][1]), lane_mask,
          model_mask(16'h0, 4'h0, 4'h0, 8'h00, cases[k][0], cases[k][1]));
    end
    tail(3, 7);
    chk("R3 size code 7", lane_mask, 16'hFFFF);
    tail(100, 4);
  endtask

  task automatic t_beat();
    logic [7:0] st[5] = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h21};
    logic [15:0] ex[5] = '{16'hFFF0, 16'hFF00, 16'hF000, 16'hF000, 16'hFFFF};
    foreach (st[k]) begin
      load(16'h0, 4'h0, 4'h0, st[k]);
      chk($sformatf("R4 beat %h", st[k]), lane_mask, ex[k]);
      chk("R5 no err", beat_err, 1'b0);
    end
    load(16'h0, 4'h0, 4'h0, 8'h70);
    chk("R5 unknown mask", lane_mask, 16'hFFFF);
    chk("R5 unknown err", beat_err, 1'b1);
    load(16'h0, 4'h0, 4'h0, 8'hF0);
    chk("R5 code 15 err", beat_err, 1'b1);
  endtask

  task automatic t_beat_adv();
    load(16'h0, 4'h0, 4'h0, 8'h40);
    step();
    chk("R6 resume to beat0", beat_q, 8'h10);
    step();
    chk("R6 beat0 to none", beat_q, 8'h00);
    load(16'h0, 4'h0, 4'h0, 8'h21);
    step();
    chk("R6 cond state kept", beat_q, 8'h21);
  endtask

  task automatic t_vpt();
    load(16'h1234, 4'h0, 4'h0, 8'h00);
    step();
    chk("R7 idle p0", p0_q, 16'h1234);
    chk("R7 idle blk", {blk_hi_q, blk_lo_q}, 8'h00);
    load(16'h1234, 4'hC, 4'h8, 8'h00);
    step();
    chk("R8 low flip", p0_q, 16'h12CB);
    chk("R8 shift", {blk_hi_q, blk_lo_q}, 8'h08);
    step();
    chk("R8 exact 1000 no flip", p0_q, 16'h12CB);
    chk("R8 expire", {blk_hi_q, blk_lo_q}, 8'h00);
    chk("R8 expired mask", lane_mask, 16'hFFFF);
    load(16'h1234, 4'h9, 4'hF, 8'h00);
    step();
    chk("R8 both flip", p0_q, 16'hEDCB);
    chk("R8 both shift", {blk_hi_q, blk_lo_q}, 8'hE2);
  endtask

  task automatic t_priority();
    load(16'h0F0F, 4'hC, 4'hC, 8'h40);
    @(negedge clk);
    load_en = 1'b1; adv = 1'b1;
    load_p0 = 16'h5555; load_blk_lo = 4'h9; load_blk_hi = 4'h1; load_beat = 8'h30;
    @(negedge clk);
    load_en = 1'b0; adv = 1'b0;
    chk("R9 p0", p0_q, 16'h5555);
    chk("R9 blk", {blk_hi_q, blk_lo_q}, 8'h19);
    chk("R9 beat", beat_q, 8'h30);
  endtask

  task automatic t_combined();
    load(16'hFFFF, 4'h4, 4'h4, 8'h10);
    tail(3, 1);
    chk("R10 combined", lane_mask, 16'h0030);
    load(16'h9F3C, 4'h2, 4'h0, 8'h20);
    tail(6, 1);
    chk("R10 combined b", lane_mask, model_mask(16'h9F3C, 4'h2, 4'h0, 8'h20, 6, 1));
    tail(100, 4);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_tail();
    t_beat();
    t_beat_adv();
    t_vpt();
    t_priority();
    t_combined();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule